// File: doc/BRIEF.md
# Card Host Control Register with Sequenced Reset

This block holds the main control word of a removable-card host controller. Software writes one 32-bit word to switch card power and the card clock on or off, to choose the fast clock, to light an activity LED, to pick the data-bus width, and to set two receive-edge options and a transmit-delay option. Each of these settings drives a plain output pin that follows its register bit.

The same word carries two reset bits, and they run as an ordered pair. Software sets the request bit first and then the hard-reset bit. Each bit drives a reset pulse into the rest of the controller. The bit clears itself once the pulse has lasted a fixed number of cycles and the logic being reset has raised its acknowledge input. A stage only makes progress while the clock-enable bit is set. The hard stage does not start while the request bit is still set. When the hard stage finishes, it returns the bus width to serial and turns the LED off, and it leaves power and clock enabled.

The read port is combinational and always shows the current register value. A write takes effect at the clock edge on which the write strobe is high. There is no data stream, so every pin is a plain level signal.

Top module: `hcr_host_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, and every control output and both reset pulses are low.
- R2: Writable fields: bit 3 (receive option B), bits 5:4 (bus width), bit 6 (clock enable), bit 7 (power enable), bit 9 (fast clock), bit 10 (LED), bit 14 (receive option A) and bit 18 (transmit delay). Each reads back as written. All bits other than these and bits 15 and 8 always read 0.
- R3: The bus-width codes are 0 for serial, 1 for 4-bit and 3 for 8-bit. A write that carries code 2 leaves the width field unchanged and still updates the other fields.
- R4: Writing 1 to bit 15 (reset request) while bit 6 is 1 starts the request stage. Bit 15 reads 1 and `rst_req_pulse` is high for exactly STAGE_CYCLES cycles, counted from the edge that takes the write, and then bit 15 reads 0.
- R5: If `req_ack` is low when the stage time has run out, bit 15 stays 1 and the pulse stays high until `req_ack` goes high. Bit 15 then clears at the next edge.
- R6: While bit 6 is 0, a pending stage does not advance and its pulse is low. Once bit 6 is set, the stage runs for its full STAGE_CYCLES.
- R7: A write of 0 to bit 15 or bit 8 leaves a set bit set. Only completion of the stage clears it.
- R8: Bit 8 (hard reset) may be written together with bit 15. `rst_hard_pulse` stays low while bit 15 is 1. Once bit 15 clears, the hard stage runs for STAGE_CYCLES cycles and bit 8 then clears.
- R9: When the hard stage completes, bits 5:4 and bit 10 become 0. Power, clock, fast-clock and the option bits keep their values.
- R10: The outputs `pwr_en`, `card_clk_en`, `fast_clk`, `led_on`, `bus_width`, `rx_opt_a`, `rx_opt_b` and `tx_delay_en` each equal their register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| req_ack | input | 1 | Acknowledge from the logic reset by the request stage |
| hard_ack | input | 1 | Acknowledge from the logic reset by the hard stage |
| rst_req_pulse | output | 1 | Request-stage reset pulse |
| rst_hard_pulse | output | 1 | Hard-stage reset pulse |
| pwr_en | output | 1 | Card power enable |
| card_clk_en | output | 1 | Card clock enable |
| fast_clk | output | 1 | Fast clock select |
| led_on | output | 1 | Activity LED |
| bus_width | output | 2 | Bus width code |
| rx_opt_a | output | 1 | Receive edge option A |
| rx_opt_b | output | 1 | Receive edge option B |
| tx_delay_en | output | 1 | Transmit delay enable |

## Verification
The reset sequencer is tried with four kinds of stimulus: a plain request with the acknowledge held high, which measures the exact pulse length; a request whose acknowledge arrives late, which separates "time expired" from "stage complete"; a request written with the clock enable off, which shows the gating and also the rule that software cannot clear the bit; and a combined request and hard-reset write, which checks the ordering and the fields that hard completion wipes. The field path is tried with an all-ones write, to catch mask and position errors, and with each width code including the illegal one.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_RXB   = 3;
  localparam int unsigned B_WLO   = 4;
  localparam int unsigned B_CLK   = 6;
  localparam int unsigned B_PWR   = 7;
  localparam int unsigned B_HARD  = 8;
  localparam int unsigned B_FAST  = 9;
  localparam int unsigned B_LED   = 10;
  localparam int unsigned B_RXA   = 14;
  localparam int unsigned B_REQ   = 15;
  localparam int unsigned B_TXD   = 18;

  typedef enum logic [1:0] {
    WID_SERIAL = 2'd0,
    WID_PAR4   = 2'd1,
    WID_BAD    = 2'd2,
    WID_PAR8   = 2'd3
  } width_e;

  typedef struct packed {
    logic   rx_a;
    logic   rx_b;
    logic   tx_dly;
    logic   fast;
    logic   led;
    logic   pwr;
    logic   clk_on;
    width_e width;
  } cfg_t;
endpackage

// File: rtl/hcr_field_reg.sv
module hcr_field_reg
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hard_done,
  output cfg_t             cfg
);
  cfg_t   cfg_q;
  width_e wr_width;

  assign wr_width = width_e'(wr_data[B_WLO+1:B_WLO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (wr_en) begin
        cfg_q.rx_a   <= wr_data[B_RXA];
        cfg_q.rx_b   <= wr_data[B_RXB];
        cfg_q.tx_dly <= wr_data[B_TXD];
        cfg_q.fast   <= wr_data[B_FAST];
        cfg_q.pwr    <= wr_data[B_PWR];
        cfg_q.clk_on <= wr_data[B_CLK];
        cfg_q.led    <= wr_data[B_LED];
        if (wr_width != WID_BAD) cfg_q.width <= wr_width;
      end
      if (hard_done) begin
        cfg_q.width <= WID_SERIAL;
        cfg_q.led   <= 1'b0;
      end
    end
  end

  assign cfg = cfg_q;

  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.width != WID_BAD); // R3
  AST_HARD_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    hard_done |=> (cfg_q.width == WID_SERIAL && !cfg_q.led)); // R9
  AST_HARD_KEEPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_done && !wr_en) |=> (cfg_q.pwr == $past(cfg_q.pwr))); // R9
endmodule

// File: rtl/hcr_reset_seq.sv
module hcr_reset_seq #(
  parameter int unsigned STAGE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic set_req,
  input  logic set_hard,
  input  logic req_ack,
  input  logic hard_ack,
  output logic req_bit,
  output logic hard_bit,
  output logic req_pulse,
  output logic hard_pulse,
  output logic hard_done
);
  localparam int unsigned CW = (STAGE_CYCLES < 2) ? 1 : $clog2(STAGE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STAGE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          req_q, hard_q;
  logic          req_run, hard_run, expired, req_fin, hard_fin;

  assign req_run  = req_q & clk_en;
  assign hard_run = hard_q & ~req_q & clk_en;
  assign expired  = (cnt_q == LAST);
  assign req_fin  = req_run & expired & req_ack;
  assign hard_fin = hard_run & expired & hard_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      req_q  <= 1'b0;
      hard_q <= 1'b0;
    end else begin
      req_q  <= req_fin  ? set_req  : (req_q  | set_req);
      hard_q <= hard_fin ? set_hard : (hard_q | set_hard);
      if (req_fin || hard_fin || (set_req && !req_q))
        cnt_q <= '0;
      else if ((req_run || hard_run) && !expired)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_bit    = req_q;
  assign hard_bit   = hard_q;
  assign req_pulse  = req_run;
  assign hard_pulse = hard_run;
  assign hard_done  = hard_fin;

  AST_HARD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hard_pulse |-> !req_bit); // R8
  AST_NO_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_bit && !req_pulse) |=> req_bit); // R7
  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pulse && !req_ack) |=> req_bit); // R5
  AST_GATED_BY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pulse || hard_pulse) |-> clk_en); // R6
endmodule

// File: rtl/hcr_host_ctrl.sv
module hcr_host_ctrl
  import hcr_pkg::*;
#(
  parameter int unsigned STAGE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        req_ack,
  input  logic        hard_ack,
  output logic        rst_req_pulse,
  output logic        rst_hard_pulse,
  output logic        pwr_en,
  output logic        card_clk_en,
  output logic        fast_clk,
  output logic        led_on,
  output logic [1:0]  bus_width,
  output logic        rx_opt_a,
  output logic        rx_opt_b,
  output logic        tx_delay_en
);
  cfg_t cfg;
  logic req_bit, hard_bit, hard_done;

  hcr_field_reg u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .hard_done (hard_done),
    .cfg       (cfg)
  );

  hcr_reset_seq #(.STAGE_CYCLES(STAGE_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (cfg.clk_on),
    .set_req    (wr_en & wr_data[B_REQ]),
    .set_hard   (wr_en & wr_data[B_HARD]),
    .req_ack    (req_ack),
    .hard_ack   (hard_ack),
    .req_bit    (req_bit),
    .hard_bit   (hard_bit),
    .req_pulse  (rst_req_pulse),
    .hard_pulse (rst_hard_pulse),
    .hard_done  (hard_done)
  );

  always_comb begin
    rd_data               = '0;
    rd_data[B_RXB]        = cfg.rx_b;
    rd_data[B_WLO+1:B_WLO] = cfg.width;
    rd_data[B_CLK]        = cfg.clk_on;
    rd_data[B_PWR]        = cfg.pwr;
    rd_data[B_HARD]       = hard_bit;
    rd_data[B_FAST]       = cfg.fast;
    rd_data[B_LED]        = cfg.led;
    rd_data[B_RXA]        = cfg.rx_a;
    rd_data[B_REQ]        = req_bit;
    rd_data[B_TXD]        = cfg.tx_dly;
  end

  assign pwr_en      = cfg.pwr;
  assign card_clk_en = cfg.clk_on;
  assign fast_clk    = cfg.fast;
  assign led_on      = cfg.led;
  assign bus_width   = cfg.width;
  assign rx_opt_a    = cfg.rx_a;
  assign rx_opt_b    = cfg.rx_b;
  assign tx_delay_en = cfg.tx_dly;

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_pulse && rst_hard_pulse)); // R8
endmodule

// File: tb/test_hcr_host_ctrl.sv
module test_hcr_host_ctrl;
  localparam int unsigned STG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        req_ack = 1'b1, hard_ack = 1'b1;
  logic        rst_req_pulse, rst_hard_pulse, pwr_en, card_clk_en, fast_clk, led_on;
  logic [1:0]  bus_width;
  logic        rx_opt_a, rx_opt_b, tx_delay_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  hcr_host_ctrl #(.STAGE_CYCLES(STG)) i_hcr_host_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .req_ack(req_ack), .hard_ack(hard_ack), .rst_req_pulse(rst_req_pulse),
    .rst_hard_pulse(rst_hard_pulse), .pwr_en(pwr_en), .card_clk_en(card_clk_en),
    .fast_clk(fast_clk), .led_on(led_on), .bus_width(bus_width), .rx_opt_a(rx_opt_a),
    .rx_opt_b(rx_opt_b), .tx_delay_en(tx_delay_en));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 pulses", {30'b0, rst_req_pulse, rst_hard_pulse}, 32'h0);
    chk("R1 outputs", {23'b0, pwr_en, card_clk_en, fast_clk, led_on, bus_width,
                       rx_opt_a, rx_opt_b, tx_delay_en}, 32'h0);
  endtask

  task automatic t_fields();
    wr(32'hFFFF_7EFF);
    chk("R2 readback all-ones", rd_data, 32'h0004_46F8);
    chk("R10 pins", {23'b0, pwr_en, card_clk_en, fast_clk, led_on, bus_width,
                     rx_opt_a, rx_opt_b, tx_delay_en}, 32'h1FF);
    wr(32'h0000_0000);
    chk("R2 readback zero", rd_data, 32'h0);
  endtask

  task automatic t_width();
    wr(32'h10);
    chk("R3 width par4", {30'b0, bus_width}, 32'd1);
    wr(32'h20 | 32'h80);
    chk("R3 code 2 ignored, power updated", rd_data, 32'h90);
    wr(32'h30);
    chk("R3 width par8", rd_data, 32'h30);
    wr(32'h0);
  endtask

  task automatic t_req_basic();
    int cnt = 0;
    wr(32'h8040);
    for (int i = 0; i < 20 && rd_data[15]; i++) begin
      if (rst_req_pulse) cnt++;
      @(negedge clk);
    end
    chk("R4 pulse length", cnt, STG);
    chk("R4 bit cleared", rd_data, 32'h40);
    chk("R4 pulse low after", {31'b0, rst_req_pulse}, 32'h0);
  endtask

  task automatic t_late_ack();
    req_ack = 1'b0;
    wr(32'h8040);
    idle(STG + 4);
    chk("R5 bit held without ack", {31'b0, rd_data[15]}, 32'h1);
    chk("R5 pulse held without ack", {31'b0, rst_req_pulse}, 32'h1);
    req_ack = 1'b1;
    @(negedge clk);
    chk("R5 cleared one edge after ack", {31'b0, rd_data[15]}, 32'h0);
  endtask

  task automatic t_clk_gate();
    int cnt = 0;
    wr(32'h0);
    wr(32'h8000);
    idle(10);
    chk("R6 pending without clock", {31'b0, rd_data[15]}, 32'h1);
    chk("R6 pulse low without clock", {31'b0, rst_req_pulse}, 32'h0);
    wr(32'h0);
    chk("R7 zero write keeps request", {31'b0, rd_data[15]}, 32'h1);
    wr(32'h0100);
    wr(32'h0);
    chk("R7 zero write keeps hard", {31'b0, rd_data[8]}, 32'h1);
    wr(32'h0040);
    for (int i = 0; i < 20 && rd_data[15]; i++) begin
      if (rst_req_pulse) cnt++;
      @(negedge clk);
    end
    chk("R6 full length after enable", cnt, STG);
    for (int i = 0; i < 20 && rd_data[8]; i++) @(negedge clk);
    chk("R8 hard drained", {31'b0, rd_data[8]}, 32'h0);
  endtask

  task automatic t_order();
    int ov = 0;
    int hc = 0;
    wr(32'h06F0);
    wr(32'h87F0);
    chk("R8 both bits set", {30'b0, rd_data[15], rd_data[8]}, 32'h3);
    for (int i = 0; i < 20 && rd_data[15]; i++) begin
      if (rst_hard_pulse) ov++;
      @(negedge clk);
    end
    chk("R8 hard pulse low during request", ov, 0);
    for (int i = 0; i < 20 && rd_data[8]; i++) begin
      if (rst_hard_pulse) hc++;
      @(negedge clk);
    end
    chk("R8 hard pulse length", hc, STG);
    chk("R9 width and LED wiped, rest kept", rd_data, 32'h02C0);
    chk("R9 pins", {28'b0, pwr_en, card_clk_en, led_on, |bus_width}, 32'hC);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fields();
    t_width();
    t_req_basic();
    t_late_ack();
    t_clk_gate();
    t_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule